// File: doc/BRIEF.md
# Type-0 Configuration Header Register Block

This block holds the standard configuration header of one PCI function: identification words, the command and status halfwords, the cache line size and interrupt line bytes, and six base address registers. A host reaches it through a single-cycle access port that carries a byte offset, an access size in bytes, a write flag and right-aligned write data. Each access is answered one clock later with registered read data, an error pulse or an ignored-write pulse.

The base address registers follow the usual sizing handshake. Software writes all ones, reads back the inverted size mask, then writes the assigned base. Each register's kind (I/O or memory) and its power-of-two size are fixed when the block is elaborated. When an I/O register receives a real base address, the block presents that base, the window size and the register index to downstream address-decode logic for one cycle. The command register's two space-enable bits are brought out as continuous levels.

Top module: `cfg_header_regs`

## Requirements
- R1: An access whose size is not 1, 2 or 4 bytes makes `acc_err` high for exactly the next cycle. It changes no register and gives no read data.
- R2: An access at offset 0x40 or above also makes `acc_err` high for the next cycle. It touches no storage and gives no read data.
- R3: A 4-byte write of 0xFFFFFFFF to a base register stores ~(size-1) in the bits above the read-only low field. A later read then returns the size mask, with the low field unchanged.
- R4: In an I/O base register, bits [1:0] read as 2'b01 at all times and no write changes them.
- R5: In a memory base register, bits [3:0] read as 4'h0 at all times and no write changes them.
- R6: Writes take effect only in these cases: 1-byte writes at 0x0C (cache line size) and 0x3C (interrupt line); 2-byte writes at 0x04 (command) and 0x06 (status); 4-byte writes at 0x10, 0x14, 0x18, 0x1C, 0x20 and 0x24. Base register index is (offset-0x10)>>2.
- R7: Any other write inside the header with a valid size changes nothing, and `ro_write` is high for exactly the next cycle.
- R8: A read asserts `rd_valid` for the next cycle. `rd_data` then holds the bytes starting at the offset, in little-endian order (lowest address in bits [7:0]), zero-extended above the access size. A read in the cycle after a write sees the written value.
- R9: A 4-byte write to an I/O base register with data other than 0xFFFFFFFF, and with some bit other than bit 0 set, pulses `win_valid` for the next cycle. With it come `win_base` = data with bit 0 cleared, `win_size` = the register's size and `win_index` = its index. No other write pulses `win_valid`.
- R10: After reset, offset 0x00 reads {device id, vendor id} and 0x08 reads the class/revision word. Command, status, cache line size and interrupt line read 0. I/O base registers read 1 and memory base registers read 0.
- R11: `io_space_en` equals command bit 0 and `mem_space_en` equals command bit 1. Both follow a command write on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 8 | Byte offset into configuration space |
| acc_size | input | 3 | Access size in bytes |
| acc_wdata | input | 32 | Write data, right-aligned |
| rd_valid | output | 1 | Read data valid (one cycle after the read) |
| rd_data | output | 32 | Read data, little-endian, zero-extended |
| acc_err | output | 1 | Pulse: bad size or offset beyond the header |
| ro_write | output | 1 | Pulse: write to an offset/size that is not writable |
| win_valid | output | 1 | Pulse: new I/O window decoded |
| win_index | output | 3 | Base register index of the window |
| win_base | output | 32 | Window base address |
| win_size | output | 32 | Window size in bytes |
| io_space_en | output | 1 | Command I/O space enable |
| mem_space_en | output | 1 | Command memory space enable |

## Verification
The port takes one access per cycle but answers it one cycle later. The response to a write therefore always shares a clock with the next access being presented, and that access may be a read of the same register. The bench issues writes to the command, status and base registers and follows each at once with a read of the same offset. It does the same with sizing writes, where the read must see the size mask. A behavioural byte-level model computes every expected response, and the bench compares every output on every cycle, including the idle and reset cycles where each pulse must be low.

// File: rtl/cfg_hdr_pkg.sv
`timescale 1ns/1ps
// Shared constants and the access-class type for the configuration header.
// Assumes a 64-byte Type-0 header; offsets are byte addresses.
package cfg_hdr_pkg;

    localparam int unsigned HDR_BYTES = 64;
    localparam int unsigned DW        = 32;
    localparam int unsigned NUM_BARS  = 6;
    localparam int unsigned IDX_W     = 3;

    localparam logic [7:0] OFF_CMD       = 8'h04;
    localparam logic [7:0] OFF_STAT      = 8'h06;
    localparam logic [7:0] OFF_CLS       = 8'h0C;
    localparam logic [7:0] OFF_BAR_FIRST = 8'h10;
    localparam logic [7:0] OFF_BAR_LAST  = 8'h24;
    localparam logic [7:0] OFF_INTLINE   = 8'h3C;

    typedef enum logic [3:0] {
        K_IDLE,
        K_ERR,
        K_READ,
        K_WR_CLS,
        K_WR_INTL,
        K_WR_CMD,
        K_WR_STAT,
        K_WR_BAR,
        K_WR_DROP
    } acc_kind_e;

endpackage

// File: rtl/cfg_acc_decode.sv
`timescale 1ns/1ps
// Classifies one access by size and offset into the action the register file
// takes. Assumes inputs are stable for the cycle; purely combinational.
module cfg_acc_decode
    import cfg_hdr_pkg::*;
(
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [7:0]       acc_offset,
    input  logic [2:0]       acc_size,
    output acc_kind_e        kind,
    output logic [IDX_W-1:0] bar_idx
);

    logic size_ok;
    logic in_hdr;
    logic bar_hit;

    // Qualify size and offset, then pick the single action for this access.
    always_comb begin
        size_ok = (acc_size == 3'd1) || (acc_size == 3'd2) || (acc_size == 3'd4);
        in_hdr  = acc_offset < 8'(HDR_BYTES);
        bar_hit = (acc_offset >= OFF_BAR_FIRST) && (acc_offset <= OFF_BAR_LAST)
                  && (acc_offset[1:0] == 2'b00);
        bar_idx = IDX_W'((acc_offset - OFF_BAR_FIRST) >> 2);
        kind    = K_IDLE;
        if (acc_valid) begin
            if (!size_ok || !in_hdr) begin
                kind = K_ERR;
            end else if (!acc_write) begin
                kind = K_READ;
            end else begin
                kind = K_WR_DROP;
                case (acc_size)
                    3'd1: begin
                        if (acc_offset == OFF_CLS)          kind = K_WR_CLS;
                        else if (acc_offset == OFF_INTLINE) kind = K_WR_INTL;
                    end
                    3'd2: begin
                        if (acc_offset == OFF_CMD)       kind = K_WR_CMD;
                        else if (acc_offset == OFF_STAT) kind = K_WR_STAT;
                    end
                    3'd4: begin
                        if (bar_hit) kind = K_WR_BAR;
                    end
                    default: kind = K_WR_DROP;
                endcase
            end
        end
    end

endmodule

// File: rtl/cfg_bar_slot.sv
`timescale 1ns/1ps
// One base address register. Kind (I/O or memory) and power-of-two size are
// elaboration constants. Handles the all-ones sizing write, keeps the
// read-only low field, and flags a new I/O window on a real base write.
module cfg_bar_slot #(
    parameter bit          IS_IO   = 1'b0,
    parameter int unsigned SZ_LOG2 = 12,
    parameter int unsigned W       = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] bar_q,
    output logic         win_fire,
    output logic [W-1:0] win_base
);

    localparam logic [W-1:0] LOW_RO    = IS_IO ? W'(3) : W'(15);
    localparam logic [W-1:0] SIZE_MASK = ~((W'(1) << SZ_LOG2) - W'(1));
    localparam logic [W-1:0] RST_VAL   = IS_IO ? W'(1) : '0;

    logic         sizing;
    logic [W-1:0] upper_src;

    // Choose between the size mask (sizing probe) and the written address.
    always_comb begin
        sizing    = &wdata;
        upper_src = sizing ? SIZE_MASK : wdata;
    end

    // Register update keeping the read-only low field.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bar_q <= RST_VAL;
        else if (wr_en)
            bar_q <= (upper_src & ~LOW_RO) | (bar_q & LOW_RO);
    end

    generate
        if (IS_IO) begin : g_io
            // Window announcement for a real I/O base write.
            always_comb begin
                win_fire = wr_en && !sizing && ((wdata & ~W'(1)) != '0);
                win_base = wdata & ~W'(1);
            end

            p_io_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
                bar_q[1:0] == 2'b01);
        end else begin : g_mem
            // Memory registers never announce a window.
            always_comb begin
                win_fire = 1'b0;
                win_base = '0;
            end

            p_mem_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
                bar_q[3:0] == 4'h0);
        end
    endgenerate

endmodule

// File: rtl/cfg_read_mux.sv
`timescale 1ns/1ps
// Builds the 64-byte header image and extracts a 1/2/4-byte little-endian
// read, zero-extended to the bus. Assumes offset is inside the header.
module cfg_read_mux
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h0000,
    parameter logic [15:0] DEVICE_ID = 16'h0000,
    parameter logic [31:0] CLASS_REV = 32'h0
) (
    input  logic [5:0]             offset,
    input  logic [2:0]             size,
    input  logic [15:0]            cmd_q,
    input  logic [15:0]            stat_q,
    input  logic [7:0]             cls_q,
    input  logic [7:0]             intl_q,
    input  logic [NUM_BARS*DW-1:0] bar_flat,
    output logic [DW-1:0]          rdata
);

    logic [7:0] img [HDR_BYTES];

    // Lay out the header as bytes, lowest address = least significant byte.
    always_comb begin
        for (int i = 0; i < int'(HDR_BYTES); i++) img[i] = 8'h00;
        img[0]  = VENDOR_ID[7:0];
        img[1]  = VENDOR_ID[15:8];
        img[2]  = DEVICE_ID[7:0];
        img[3]  = DEVICE_ID[15:8];
        img[4]  = cmd_q[7:0];
        img[5]  = cmd_q[15:8];
        img[6]  = stat_q[7:0];
        img[7]  = stat_q[15:8];
        for (int k = 0; k < 4; k++) img[8 + k] = CLASS_REV[8*k +: 8];
        img[12] = cls_q;
        for (int b = 0; b < int'(NUM_BARS); b++)
            for (int k = 0; k < 4; k++)
                img[16 + 4*b + k] = bar_flat[DW*b + 8*k +: 8];
        img[60] = intl_q;
    end

    logic [6:0] addr;

    // Gather up to four consecutive bytes into the read lanes.
    always_comb begin
        rdata = '0;
        addr  = '0;
        for (int i = 0; i < 4; i++) begin
            addr = 7'(offset) + 7'(i);
            if ((i < int'(size)) && (addr < 7'(HDR_BYTES)))
                rdata[8*i +: 8] = img[addr[5:0]];
        end
    end

endmodule

// File: rtl/cfg_header_regs.sv
`timescale 1ns/1ps
// Type-0 configuration header register block for one function.
// One access per cycle in; registered response one cycle later.
// Assumes acc_* inputs are sampled only when acc_valid is high.
module cfg_header_regs
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0]             VENDOR_ID   = 16'hC0DE,
    parameter logic [15:0]             DEVICE_ID   = 16'h5A17,
    parameter logic [31:0]             CLASS_REV   = 32'h0780_0001,
    parameter logic [NUM_BARS-1:0]     BAR_IS_IO   = 6'b001001,
    parameter logic [NUM_BARS*5-1:0]   BAR_SZ_LOG2 = {5'd16, 5'd4, 5'd5, 5'd20, 5'd12, 5'd8}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [7:0]       acc_offset,
    input  logic [2:0]       acc_size,
    input  logic [31:0]      acc_wdata,
    output logic             rd_valid,
    output logic [31:0]      rd_data,
    output logic             acc_err,
    output logic             ro_write,
    output logic             win_valid,
    output logic [2:0]       win_index,
    output logic [31:0]      win_base,
    output logic [31:0]      win_size,
    output logic             io_space_en,
    output logic             mem_space_en
);

    acc_kind_e             kind;
    logic [IDX_W-1:0]      bar_idx;
    logic [15:0]           cmd_q;
    logic [15:0]           stat_q;
    logic [7:0]            cls_q;
    logic [7:0]            intl_q;
    logic [NUM_BARS*DW-1:0] bar_flat;
    logic [NUM_BARS-1:0]   bar_wr;
    logic [NUM_BARS-1:0]   bar_fire;
    logic [DW-1:0]         bar_wbase [NUM_BARS];
    logic [DW-1:0]         bar_size  [NUM_BARS];
    logic [DW-1:0]         mux_rdata;
    logic                  fire_any;
    logic [IDX_W-1:0]      fire_idx;
    logic [DW-1:0]         fire_base;
    logic [DW-1:0]         fire_size;

    cfg_acc_decode u_dec (
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_offset (acc_offset),
        .acc_size   (acc_size),
        .kind       (kind),
        .bar_idx    (bar_idx)
    );

    genvar gb;
    generate
        for (gb = 0; gb < int'(NUM_BARS); gb++) begin : g_bar
            localparam int unsigned LG = BAR_SZ_LOG2[5*gb +: 5];

            // Write strobe for this register.
            always_comb bar_wr[gb] = (kind == K_WR_BAR) && (bar_idx == IDX_W'(gb));

            assign bar_size[gb] = DW'(1) << LG;

            cfg_bar_slot #(
                .IS_IO   (BAR_IS_IO[gb]),
                .SZ_LOG2 (LG),
                .W       (DW)
            ) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (bar_wr[gb]),
                .wdata    (acc_wdata),
                .bar_q    (bar_flat[DW*gb +: DW]),
                .win_fire (bar_fire[gb]),
                .win_base (bar_wbase[gb])
            );
        end
    endgenerate

    cfg_read_mux #(
        .VENDOR_ID (VENDOR_ID),
        .DEVICE_ID (DEVICE_ID),
        .CLASS_REV (CLASS_REV)
    ) u_rmux (
        .offset   (acc_offset[5:0]),
        .size     (acc_size),
        .cmd_q    (cmd_q),
        .stat_q   (stat_q),
        .cls_q    (cls_q),
        .intl_q   (intl_q),
        .bar_flat (bar_flat),
        .rdata    (mux_rdata)
    );

    // Select the register (at most one) announcing a window this cycle.
    always_comb begin
        fire_any  = 1'b0;
        fire_idx  = '0;
        fire_base = '0;
        fire_size = '0;
        for (int b = 0; b < int'(NUM_BARS); b++) begin
            if (bar_fire[b]) begin
                fire_any  = 1'b1;
                fire_idx  = IDX_W'(b);
                fire_base = bar_wbase[b];
                fire_size = bar_size[b];
            end
        end
    end

    // Scalar header fields written by their own offset and size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            stat_q <= '0;
            cls_q  <= '0;
            intl_q <= '0;
        end else begin
            case (kind)
                K_WR_CMD:  cmd_q  <= acc_wdata[15:0];
                K_WR_STAT: stat_q <= acc_wdata[15:0];
                K_WR_CLS:  cls_q  <= acc_wdata[7:0];
                K_WR_INTL: intl_q <= acc_wdata[7:0];
                default: ;
            endcase
        end
    end

    // Registered response: read data and one-cycle status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            acc_err  <= 1'b0;
            ro_write <= 1'b0;
        end else begin
            rd_valid <= (kind == K_READ);
            rd_data  <= (kind == K_READ) ? mux_rdata : '0;
            acc_err  <= (kind == K_ERR);
            ro_write <= (kind == K_WR_DROP);
        end
    end

    // Window report towards the address decoder; fields hold between pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_valid <= 1'b0;
            win_index <= '0;
            win_base  <= '0;
            win_size  <= '0;
        end else begin
            win_valid <= fire_any;
            if (fire_any) begin
                win_index <= fire_idx;
                win_base  <= fire_base;
                win_size  <= fire_size;
            end
        end
    end

    assign io_space_en  = cmd_q[0];
    assign mem_space_en = cmd_q[1];

    p_err_nochg_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> ($stable(cmd_q) && $stable(stat_q) && $stable(cls_q)
                     && $stable(intl_q) && $stable(bar_flat)));

    p_err_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> (!rd_valid && !ro_write && !win_valid));

    p_ro_nochg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ro_write |-> ($past(acc_valid && acc_write) && $stable(cmd_q)
                      && $stable(stat_q) && $stable(bar_flat)));

    p_rd_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(acc_valid && !acc_write));

    p_win_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> ($past(acc_valid && acc_write && acc_size == 3'd4)
                       && $onehot0(BAR_IS_IO & (6'b1 << win_index))));

    p_pulse_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, acc_err, ro_write}));

endmodule

// File: tb/cfg_header_regs_tb.sv
`timescale 1ns/1ps
// Bench: queued accesses, a behavioural byte-level model, and a comparison of
// every output on every clock.
module cfg_header_regs_tb;

    localparam bit [15:0] VEN = 16'hC0DE;
    localparam bit [15:0] DEV = 16'h5A17;
    localparam bit [31:0] CRV = 32'h0780_0001;

    typedef struct packed {
        bit        wr;
        bit [7:0]  off;
        bit [2:0]  sz;
        bit [31:0] d;
        bit [31:0] tag;
    } acc_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0, acc_write = 1'b0;
    logic [7:0] acc_offset = '0;
    logic [2:0] acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic rd_valid, acc_err, ro_write, win_valid, io_space_en, mem_space_en;
    logic [31:0] rd_data, win_base, win_size;
    logic [2:0] win_index;

    always #2.5 clk = ~clk;

    cfg_header_regs u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_offset(acc_offset), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .acc_err(acc_err), .ro_write(ro_write),
        .win_valid(win_valid), .win_index(win_index), .win_base(win_base),
        .win_size(win_size), .io_space_en(io_space_en), .mem_space_en(mem_space_en)
    );

    acc_t q[$];
    int n_chk = 0;
    int n_fail = 0;

    // Model state
    bit [15:0] m_cmd = 0, m_stat = 0;
    bit [7:0]  m_cls = 0, m_il = 0;
    bit [31:0] m_bar [6] = '{32'h1, 32'h0, 32'h0, 32'h1, 32'h0, 32'h0};
    int        lg [6] = '{8, 12, 20, 5, 4, 16};
    bit        io [6] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

    // Expected outputs for the access presented last cycle
    bit e_rv = 0, e_err = 0, e_ro = 0, e_win = 0;
    bit [31:0] e_rd = 0, e_wb = 0, e_ws = 0;
    bit [2:0]  e_wi = 0;
    bit [31:0] e_tag = "R10";

    task automatic check(input bit ok, input bit [31:0] tag, input bit [31:0] act, input bit [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    task automatic push(input bit wr, input bit [7:0] off, input bit [2:0] sz,
                        input bit [31:0] d, input bit [31:0] tag);
        acc_t a;
        a.wr = wr; a.off = off; a.sz = sz; a.d = d; a.tag = tag;
        q.push_back(a);
    endtask

    function automatic bit [7:0] byte_at(int a);
        bit [31:0] w;
        w = 0;
        if (a >= 64) return 8'h00;
        case (a / 4)
            0: w = {DEV, VEN};
            1: w = {m_stat, m_cmd};
            2: w = CRV;
            3: w = {24'h0, m_cls};
            4, 5, 6, 7, 8, 9: w = m_bar[a/4 - 4];
            15: w = {24'h0, m_il};
            default: w = 0;
        endcase
        return w[8*(a%4) +: 8];
    endfunction

    task automatic model(input acc_t a);
        int b;
        bit [31:0] low, val;
        e_rv = 0; e_err = 0; e_ro = 0; e_win = 0; e_rd = 0; e_tag = a.tag;
        if (!(a.sz == 1 || a.sz == 2 || a.sz == 4) || a.off >= 64) begin
            e_err = 1;
        end else if (!a.wr) begin
            e_rv = 1;
            for (int i = 0; i < int'(a.sz); i++)
                e_rd |= 32'(byte_at(int'(a.off) + i)) << (8*i);
        end else if (a.sz == 1 && a.off == 8'h0C) m_cls = a.d[7:0];
        else if (a.sz == 1 && a.off == 8'h3C) m_il = a.d[7:0];
        else if (a.sz == 2 && a.off == 8'h04) m_cmd = a.d[15:0];
        else if (a.sz == 2 && a.off == 8'h06) m_stat = a.d[15:0];
        else if (a.sz == 4 && a.off >= 8'h10 && a.off <= 8'h24 && a.off % 4 == 0) begin
            b = (int'(a.off) - 16) / 4;
            low = io[b] ? 32'h3 : 32'hF;
            val = (a.d == 32'hFFFF_FFFF) ? ~((32'd1 << lg[b]) - 32'd1) : a.d;
            m_bar[b] = (val & ~low) | (m_bar[b] & low);
            if (io[b] && a.d != 32'hFFFF_FFFF && (a.d & ~32'h1) != 0) begin
                e_win = 1; e_wb = a.d & ~32'h1; e_ws = 32'd1 << lg[b]; e_wi = 3'(b);
            end
        end else e_ro = 1;
    endtask

    task automatic compare_all();
        check(rd_valid == e_rv, e_tag, 32'(rd_valid), 32'(e_rv));
        if (e_rv) check(rd_data == e_rd, e_tag, rd_data, e_rd);
        check(acc_err == e_err, e_tag, 32'(acc_err), 32'(e_err));   // R1 / R2
        check(ro_write == e_ro, "R7", 32'(ro_write), 32'(e_ro));
        check(win_valid == e_win, "R9", 32'(win_valid), 32'(e_win));
        if (e_win) begin
            check(win_base == e_wb, "R9", win_base, e_wb);
            check(win_size == e_ws, "R9", win_size, e_ws);
            check(win_index == e_wi, "R9", 32'(win_index), 32'(e_wi));
        end
        check(io_space_en == m_cmd[0], "R11", 32'(io_space_en), 32'(m_cmd[0]));
        check(mem_space_en == m_cmd[1], "R11", 32'(mem_space_en), 32'(m_cmd[1]));
    endtask

    initial begin
        // R10: reset contents
        push(0, 8'h00, 4, 0, "R10"); push(0, 8'h08, 4, 0, "R10");
        push(0, 8'h10, 4, 0, "R10"); push(0, 8'h14, 4, 0, "R10");
        push(0, 8'h1C, 4, 0, "R10"); push(0, 8'h04, 4, 0, "R10");
        push(0, 8'h3C, 4, 0, "R10");
        // R6 / R11 / R8: command write followed at once by a read
        push(1, 8'h04, 2, 32'h0003, "R6"); push(0, 8'h04, 2, 0, "R8");
        push(1, 8'h04, 2, 32'h0002, "R11"); push(0, 8'h04, 4, 0, "R8");
        push(1, 8'h06, 2, 32'hABCD, "R6"); push(0, 8'h04, 4, 0, "R8");
        push(0, 8'h07, 1, 0, "R8"); push(0, 8'h06, 2, 0, "R8");
        push(1, 8'h0C, 1, 32'h10, "R6"); push(1, 8'h3C, 1, 32'h0B, "R6");
        push(0, 8'h3C, 4, 0, "R8"); push(0, 8'h0C, 1, 0, "R8"); push(0, 8'h0D, 2, 0, "R8");
        push(0, 8'h3F, 1, 0, "R8"); push(0, 8'h02, 2, 0, "R8");
        // R7: writes that must be dropped
        push(1, 8'h04, 1, 32'hFF, "R7"); push(1, 8'h00, 4, 32'h1234_5678, "R7");
        push(1, 8'h0C, 2, 32'hFFFF, "R7"); push(1, 8'h12, 4, 32'hFFFF_FFFF, "R7");
        push(1, 8'h28, 4, 32'hFFFF_FFFF, "R7"); push(1, 8'h3C, 2, 32'h55, "R7");
        push(1, 8'h10, 2, 32'hFFFF, "R7");
        push(0, 8'h04, 4, 0, "R7"); push(0, 8'h0C, 4, 0, "R7"); push(0, 8'h10, 4, 0, "R7");
        push(0, 8'h3C, 4, 0, "R7"); push(0, 8'h00, 4, 0, "R7");
        // R1: bad sizes
        push(1, 8'h10, 3, 32'hFFFF_FFFF, "R1"); push(0, 8'h10, 0, 0, "R1");
        push(1, 8'h04, 7, 32'hFFFF, "R1"); push(0, 8'h10, 4, 0, "R1"); push(0, 8'h04, 4, 0, "R1");
        // R2: beyond the header
        push(0, 8'h40, 4, 0, "R2"); push(1, 8'h80, 4, 32'hFFFF_FFFF, "R2");
        push(1, 8'h44, 1, 32'hAA, "R2"); push(0, 8'hFF, 1, 0, "R2");
        // R3: sizing probes and back-to-back readback
        push(1, 8'h10, 4, 32'hFFFF_FFFF, "R3"); push(0, 8'h10, 4, 0, "R3");
        push(1, 8'h14, 4, 32'hFFFF_FFFF, "R3"); push(0, 8'h14, 4, 0, "R3");
        push(1, 8'h18, 4, 32'hFFFF_FFFF, "R3"); push(0, 8'h18, 4, 0, "R3");
        push(1, 8'h1C, 4, 32'hFFFF_FFFF, "R3"); push(0, 8'h1C, 4, 0, "R3");
        push(1, 8'h20, 4, 32'hFFFF_FFFF, "R3"); push(0, 8'h20, 4, 0, "R3");
        push(1, 8'h24, 4, 32'hFFFF_FFFF, "R3"); push(0, 8'h24, 4, 0, "R3");
        // R4 / R9: I/O base writes
        push(1, 8'h10, 4, 32'h0000_1003, "R9"); push(0, 8'h10, 4, 0, "R4");
        push(1, 8'h10, 4, 32'h0000_0001, "R9"); push(0, 8'h10, 4, 0, "R4");
        push(1, 8'h1C, 4, 32'h0000_2002, "R9"); push(0, 8'h1C, 4, 0, "R4");
        push(1, 8'h10, 4, 32'hFFFF_FFFE, "R9"); push(0, 8'h10, 4, 0, "R4");
        push(1, 8'h10, 4, 32'h0000_0000, "R9"); push(0, 8'h12, 2, 0, "R8");
        // R5: memory base writes
        push(1, 8'h18, 4, 32'hF000_000F, "R5"); push(0, 8'h18, 4, 0, "R5");
        push(1, 8'h24, 4, 32'h1234_5678, "R5"); push(0, 8'h24, 4, 0, "R5");
        push(1, 8'h20, 4, 32'h0000_0005, "R5"); push(0, 8'h20, 4, 0, "R5");
        push(0, 8'h26, 2, 0, "R8");

        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(rd_valid == 0 && acc_err == 0 && ro_write == 0 && win_valid == 0, "R10",
              {28'h0, rd_valid, acc_err, ro_write, win_valid}, 32'h0);
        rst_n = 1'b1;
        while (q.size() > 0) begin
            acc_t a;
            @(negedge clk);
            compare_all();
            a = q.pop_front();
            acc_valid = 1'b1; acc_write = a.wr; acc_offset = a.off;
            acc_size = a.sz; acc_wdata = a.d;
            model(a);
        end
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            compare_all();
            acc_valid = 1'b0; acc_write = 1'b0; acc_wdata = '0;
            e_rv = 0; e_err = 0; e_ro = 0; e_win = 0; e_tag = "R8";
        end
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5ns * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired R8 actual=%0d expected=0", q.size());
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule